// File: doc/BRIEF.md
# Stacked Capacitor Switch Sequencer

This block is the switch controller for a bipolar stacked switched-capacitor energy buffer. The buffer has two backbone capacitors and five supporting capacitors. The controller holds one of 22 switch configurations at a time. It moves one configuration forward each time the bus reaches its upper ripple limit while the buffer absorbs energy. It moves one configuration back each time the bus falls to its lower limit while the buffer gives energy up. Both ends of the sequence saturate.

Each half of the sequence serves one backbone capacitor and runs in three parts. First the forward bridge pair is on with each supporting capacitor in ascending order. Next comes one direct state, in which two bridge switches on the same side place the backbone capacitor straight across the bus. The direct bridge code differs between the two halves. Last, the reverse bridge pair is on with the supporting capacitors in descending order.

The two limit comparators are asynchronous. Each is resynchronised and reduced to a single event per assertion. Every change of configuration is break-before-make: switches that turn off are released at once. Switches that turn on wait out a programmable dead time, and switches common to both configurations stay on. An enable input, normally driven when precharge is complete, holds everything off in state 1 while it is low.

Top module: `ssc_seq`

## Requirements
- R1: While reset is applied or `en` is low, every switch output is 0 and `state_idx` is 1. Once `en` is high, state 1's switches are driven after the next rising clock edge.
- R2: States 1 to 11 drive `sw_bb`=2'b01. States 1 to 5 drive `sw_br`=4'b1001 with `sw_sup` bit (state-1) set. State 6 drives `sw_br`=4'b1100 with `sw_sup`=0. States 7 to 11 drive `sw_br`=4'b0110 with `sw_sup` bit (11-state) set.
- R3: States 12 to 22 drive `sw_bb`=2'b10. Positions p = state-11 follow the same pattern as R2, except that the direct state 17 drives `sw_br`=4'b0011.
- R4: A new assertion of `lim_hi` advances the state by one. A new assertion of `lim_lo` moves it back by one.
- R5: A `lim_hi` event in state 22 and a `lim_lo` event in state 1 leave the state and the switches unchanged.
- R6: A limit flag held high for many cycles causes exactly one step.
- R7: On a step, the switches not needed by the new state go off in the same cycle that `state_idx` changes, and switches common to both states stay on. The new switches come on `dead_len`+1 cycles after that.
- R8: While both synchronised flags are high, no step occurs and `fault` is 1. `fault` returns to 0 once they are no longer both high.
- R9: A flag that rises between clock edges causes its step on the third rising edge after the change.
- R10: Bridge bits 0 and 2 are never on together, and neither are bits 1 and 3. At most one `sw_sup` bit and at most one `sw_bb` bit is on.
- R11: Limit events that arrive while a dead-time window is running are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable (precharge complete) |
| lim_hi | input | 1 | Bus at upper ripple limit, asynchronous |
| lim_lo | input | 1 | Bus at lower ripple limit, asynchronous |
| dead_len | input | DEAD_W | Dead-time length in cycles |
| sw_bb | output | 2 | Backbone selectors: bit 0 first, bit 1 second |
| sw_br | output | 4 | Bridge switches: bits 0 and 2 form one leg, bits 1 and 3 the other |
| sw_sup | output | 5 | Supporting-capacitor selectors, bit 0 lowest |
| state_idx | output | 5 | Current state, 1 to 22 |
| fault | output | 1 | Both limit flags active together |

## Verification
A wrong state register shows at the switch ports as a wrong bridge code, supporting bit or backbone bit. This appears no later than `dead_len`+4 cycles after the limit flag that caused it. A missing saturation or a lost edge qualification shows as an output change that no stimulus called for. That change becomes visible three edges after the flag moves. A broken dead-time counter shows as new switches arriving in the wrong cycle relative to the change of `state_idx`.

// File: rtl/ssc_seq.sv
module ssc_seq #(
  parameter int DEAD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              lim_hi,
  input  logic              lim_lo,
  input  logic [DEAD_W-1:0] dead_len,
  output logic [1:0]        sw_bb,
  output logic [3:0]        sw_br,
  output logic [4:0]        sw_sup,
  output logic [4:0]        state_idx,
  output logic              fault
);
  localparam logic [4:0] HALF  = 5'd11;
  localparam logic [4:0] FIRST = 5'd1;
  localparam logic [4:0] LAST  = 5'd22;

  logic [2:0]        hi_sh, lo_sh;
  logic              hi_lvl, lo_lvl, hi_ev, lo_ev;
  logic [4:0]        st, nxt;
  logic [10:0]       drv;
  logic              dead;
  logic [DEAD_W-1:0] cnt;

  function automatic logic [10:0] decode(input logic [4:0] s);
    logic       second;
    logic [4:0] p;
    logic [3:0] br;
    logic [4:0] sup;
    second = (s > HALF);
    p      = second ? s - HALF : s;
    sup    = '0;
    if (p <= 5'd5) begin
      br  = 4'b1001;
      sup = 5'd1 << (p - 5'd1);
    end else if (p == 5'd6) begin
      br  = second ? 4'b0011 : 4'b1100;
    end else begin
      br  = 4'b0110;
      sup = 5'd1 << (5'd11 - p);
    end
    return {sup, br, second ? 2'b10 : 2'b01};
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hi_sh <= '0;
      lo_sh <= '0;
    end else begin
      hi_sh <= {hi_sh[1:0], lim_hi};
      lo_sh <= {lo_sh[1:0], lim_lo};
    end

  assign hi_lvl = hi_sh[1];
  assign lo_lvl = lo_sh[1];
  assign hi_ev  = hi_sh[1] & ~hi_sh[2];
  assign lo_ev  = lo_sh[1] & ~lo_sh[2];

  assign nxt = (hi_ev && !lo_lvl && st != LAST)  ? st + 5'd1 :
               (lo_ev && !hi_lvl && st != FIRST) ? st - 5'd1 : st;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st    <= FIRST;
      drv   <= '0;
      dead  <= 1'b1;
      cnt   <= '0;
      fault <= 1'b0;
    end else if (!en) begin
      st    <= FIRST;
      drv   <= '0;
      dead  <= 1'b1;
      cnt   <= '0;
      fault <= 1'b0;
    end else begin
      fault <= hi_lvl & lo_lvl;
      if (dead) begin
        if (cnt == '0) begin
          dead <= 1'b0;
          drv  <= decode(st);
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (nxt != st) begin
        st   <= nxt;
        drv  <= drv & decode(nxt);
        dead <= 1'b1;
        cnt  <= dead_len;
      end
    end

  assign {sw_sup, sw_br, sw_bb} = drv;
  assign state_idx = st;

  AST_LEG_A_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(sw_br[0] && sw_br[2])); // R10
  AST_LEG_B_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(sw_br[1] && sw_br[3])); // R10
  AST_ONE_SUP: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(sw_sup)); // R10
  AST_ONE_BB: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(sw_bb)); // R10
  AST_STATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (st >= FIRST && st <= LAST)); // R5
  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && st != $past(st)) |-> (st == $past(st) + 5'd1 || st == $past(st) - 5'd1)); // R4
  AST_MAKE_AFTER_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
    ((drv & ~$past(drv)) != '0) |-> $stable(st)); // R7
  AST_OFF_WHEN_DIS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (drv == '0 && st == FIRST)); // R1
endmodule

// File: tb/ssc_seq_tb.sv
module ssc_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       lim_hi = 1'b0;
  logic       lim_lo = 1'b0;
  logic [3:0] dead_len = 4'd1;
  logic [1:0] sw_bb;
  logic [3:0] sw_br;
  logic [4:0] sw_sup;
  logic [4:0] state_idx;
  logic       fault;

  always #4 clk = ~clk;

  ssc_seq #(.DEAD_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .lim_hi(lim_hi), .lim_lo(lim_lo),
    .dead_len(dead_len), .sw_bb(sw_bb), .sw_br(sw_br), .sw_sup(sw_sup),
    .state_idx(state_idx), .fault(fault)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cur = 1;
  bit mon_on = 1'b0;
  logic [15:0] exp_q[$];
  string tag_q[$];
  logic [15:0] last;
  wire  [15:0] obs = {state_idx, sw_sup, sw_br, sw_bb};

  function automatic logic [10:0] model_sw(int s);
    int h, p;
    logic [4:0] sup;
    logic [3:0] br;
    h = (s - 1) / 11;
    p = (s - 1) % 11;
    sup = '0;
    if (p < 5) begin br = 4'b1001; sup[p] = 1'b1; end
    else if (p == 5) br = (h == 0) ? 4'b1100 : 4'b0011;
    else begin br = 4'b0110; sup[10 - p] = 1'b1; end
    return {sup, br, (h == 0) ? 2'b01 : 2'b10};
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string half_tag(int s);
    return (s <= 11) ? "R2" : "R3";
  endfunction

  always @(negedge clk) if (mon_on) begin
    if (obs !== last) begin
      if (exp_q.size() == 0) chk("R6 unexpected output change", obs, last);
      else chk(tag_q.pop_front(), obs, exp_q.pop_front());
      last = obs;
    end
  end

  task automatic push_step(int nw);
    exp_q.push_back({5'(nw), model_sw(cur) & model_sw(nw)}); tag_q.push_back("R7 break");
    exp_q.push_back({5'(nw), model_sw(nw)}); tag_q.push_back(half_tag(nw));
    cur = nw;
  endtask

  task automatic pulse(bit up, int hold);
    @(negedge clk);
    if (up) lim_hi = 1'b1; else lim_lo = 1'b1;
    if (up && cur < 22) push_step(cur + 1);
    if (!up && cur > 1) push_step(cur - 1);
    repeat (hold) @(negedge clk);
    lim_hi = 1'b0; lim_lo = 1'b0;
    repeat (int'(dead_len) + 8) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R4 watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] inter;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset state", obs, {5'd1, 11'b0});
    chk("R8 fault idle", {15'b0, fault}, 16'd0);
    last = obs;
    mon_on = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle while disabled", obs, {5'd1, 11'b0});

    en = 1'b1;
    exp_q.push_back({5'd1, model_sw(1)}); tag_q.push_back("R1 enable");
    repeat (4) @(negedge clk);

    for (int i = 0; i < 21; i++) pulse(1'b1, 6);
    chk("R4 reached top", {11'b0, state_idx}, 16'd22);
    pulse(1'b1, 6);
    chk("R5 saturate top", obs, {5'd22, model_sw(22)});
    for (int i = 0; i < 21; i++) pulse(1'b0, 6);
    chk("R4 reached bottom", {11'b0, state_idx}, 16'd1);
    pulse(1'b0, 6);
    chk("R5 saturate bottom", obs, {5'd1, model_sw(1)});

    @(negedge clk);
    dead_len = 4'd3;
    @(negedge clk);
    lim_hi = 1'b1;
    inter = {5'd2, model_sw(1) & model_sw(2)};
    push_step(2);
    repeat (2) @(negedge clk);
    chk("R9 no step before third edge", {11'b0, state_idx}, 16'd1);
    @(negedge clk);
    chk("R9 step on third edge", obs, inter);
    repeat (3) @(negedge clk);
    chk("R7 dead time still open", obs, inter);
    @(negedge clk);
    chk("R7 new switches after dead time", obs, {5'd2, model_sw(2)});
    repeat (3) @(negedge clk);
    lim_hi = 1'b0;
    repeat (6) @(negedge clk);

    dead_len = 4'd10;
    @(negedge clk);
    lim_hi = 1'b1;
    push_step(3);
    repeat (4) @(negedge clk);
    lim_hi = 1'b0;
    repeat (3) @(negedge clk);
    lim_hi = 1'b1;
    repeat (25) @(negedge clk);
    lim_hi = 1'b0;
    repeat (6) @(negedge clk);
    chk("R11 event in dead window dropped", obs, {5'd3, model_sw(3)});

    dead_len = 4'd1;
    @(negedge clk);
    lim_hi = 1'b1; lim_lo = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 fault raised", {15'b0, fault}, 16'd1);
    repeat (5) @(negedge clk);
    chk("R8 state held", obs, {5'd3, model_sw(3)});
    lim_hi = 1'b0; lim_lo = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 fault cleared", {15'b0, fault}, 16'd0);
    chk("R8 no step after clear", obs, {5'd3, model_sw(3)});

    en = 1'b0;
    exp_q.push_back({5'd1, 11'b0}); tag_q.push_back("R1 disable");
    cur = 1;
    repeat (4) @(negedge clk);
    en = 1'b1;
    exp_q.push_back({5'd1, model_sw(1)}); tag_q.push_back("R1 re-enable");
    repeat (4) @(negedge clk);
    chk("R1 state after re-enable", obs, {5'd1, model_sw(1)});

    chk("R7 scoreboard drained", 16'(exp_q.size()), 16'd0);
    mon_on = 1'b0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule